// File: doc/BRIEF.md
# Windowed Frame-Memory Address Counter

This block generates byte addresses for a one-bit-per-pixel image memory of 800 by 480 pixels. Each row holds 100 bytes, so the frame is 48,000 bytes. A host, working through an already-decoded command stream, does four things. It loads a rectangular window on each axis. It places the X and Y counters. It picks a stepping direction per axis. It then streams image bytes. For every image byte the block issues one memory write, with the byte, a buffer select and the linear address of the current counter position. After that write it moves the counters on by one byte.

X positions are held in pixels, but one write advances X by eight pixels, which is one byte column. Stepping on an axis can go up or down. This lets a host fill a region bottom-to-top on panels whose gate order is reversed. When X runs off its window edge it reloads and moves Y by one. When Y runs off its edge, it reloads too, so a stream longer than the window keeps cycling through the same rectangle.

Top module: `wac_addr_counter`

## Requirements
- R1: After a synchronous reset, mem_we is 0. The stepping mode is X-up and Y-up. The X window spans pixels 0 to 799 and the Y window rows 0 to 479. Both counters are 0, so the first image byte is written at address 0 and the next at address 1.
- R2: After command 0x44 (X window) or 0x45 (Y window), the next four data bytes load the window start low byte, start high byte, end low byte and end high byte, in that order. X values are in pixels.
- R3: After command 0x4E, two data bytes load the X counter in pixels, low byte first. After command 0x4F, two data bytes load the Y counter the same way.
- R4: After command 0x11, one data byte sets the mode. Bit 0 set means X counts up and clear means down. Bit 1 does the same for Y. So 0x03 steps both axes up and 0x01 steps X up and Y down.
- R5: After command 0x24 or 0x26, each accepted data byte yields, on the next cycle, mem_we=1, mem_data equal to that byte, mem_buf 0 for 0x24 or 1 for 0x26, and mem_addr = Y*100 + (X>>3).
- R6: Each image byte moves X one byte column in its direction. When the column written equals the column of the X end, X reloads the X start and Y takes one step.
- R7: When Y takes a step while it equals the Y end, Y reloads the Y start.
- R8: Data bytes are dropped when they arrive before any command, after an unrecognised command, or after a setup command has all its bytes. A dropped byte changes no register and no counter.
- R9: If a command and a data byte arrive in the same cycle, the command is taken and the data byte is dropped without a write.
- R10: An image byte whose counter position is outside the frame (column of 100 or more, or row of 480 or more) produces no write strobe, but the counters still advance.
- R11: A region of height h at row y can be filled with Y stepping down. The Y start is (480-y-h)+h-1, the Y end is 480-y-h, and the Y counter begins at the start. The writes then go from the highest row down to the lowest, then wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command byte present this cycle |
| cmd_code | input | 8 | Command byte |
| dat_valid | input | 1 | Data byte present this cycle |
| dat_byte | input | 8 | Data byte |
| mem_we | output | 1 | Memory write strobe, registered |
| mem_buf | output | 1 | Target image buffer: 0 current, 1 previous |
| mem_addr | output | 16 | Linear byte address in the frame |
| mem_data | output | 8 | Byte to store |

## Verification
The bench builds the block at its default 800 by 480 geometry. This places the last frame byte, 47999, and the full-frame double wrap back to address 0 within a few writes, once the counters are loaded near the corner. Small windows of two columns by two or three rows bring X reloads, Y steps and Y wraps into reach in five to seven bytes, in all three stepping modes used. The row and column bounds of the real frame are what make the out-of-frame suppression (row 480) and the reversed region near the bottom rows reachable.

// File: rtl/wac_pkg.sv
`timescale 1ns/1ps
package wac_pkg;

  localparam logic [7:0] OP_MODE = 8'h11;
  localparam logic [7:0] OP_XWIN = 8'h44;
  localparam logic [7:0] OP_YWIN = 8'h45;
  localparam logic [7:0] OP_XCNT = 8'h4E;
  localparam logic [7:0] OP_YCNT = 8'h4F;
  localparam logic [7:0] OP_WNEW = 8'h24;
  localparam logic [7:0] OP_WOLD = 8'h26;

  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_MODE,
    ACT_XWIN,
    ACT_YWIN,
    ACT_XCNT,
    ACT_YCNT,
    ACT_WNEW,
    ACT_WOLD
  } act_e;

  function automatic act_e decode_op(input logic [7:0] op);
    case (op)
      OP_MODE: return ACT_MODE;
      OP_XWIN: return ACT_XWIN;
      OP_YWIN: return ACT_YWIN;
      OP_XCNT: return ACT_XCNT;
      OP_YCNT: return ACT_YCNT;
      OP_WNEW: return ACT_WNEW;
      OP_WOLD: return ACT_WOLD;
      default: return ACT_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/wac_cmd_track.sv
`timescale 1ns/1ps
// Remembers the last command and counts the data bytes that follow it.
module wac_cmd_track
  import wac_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_code,
  input  logic             dat_valid,
  output act_e             act_q,
  output logic [IDX_W-1:0] idx_q,
  output logic             take
);

  // a command in the same cycle wins over a data byte
  assign take = dat_valid && !cmd_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= ACT_IDLE;
      idx_q <= '0;
    end else if (cmd_valid) begin
      act_q <= decode_op(cmd_code);
      idx_q <= '0;
    end else if (take && (idx_q != '1)) begin
      idx_q <= idx_q + 1'b1;
    end
  end

endmodule

// File: rtl/wac_win_regs.sv
`timescale 1ns/1ps
// Mode register and the four 16-bit window bounds, each loaded a byte at a time.
module wac_win_regs
  import wac_pkg::*;
#(
  parameter int H_PIX = 800,
  parameter int V_PIX = 480,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  act_e             act,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       dat_byte,
  output logic [1:0]       mode_q,
  output logic [3:0][15:0] win_q
);

  always_ff @(posedge clk) begin
    if (rst)
      mode_q <= 2'b11;
    else if (take && act == ACT_MODE && idx == '0)
      mode_q <= dat_byte[1:0];
  end

  // slot 0: X start, 1: X end, 2: Y start, 3: Y end
  for (genvar g = 0; g < 4; g++) begin : g_bound
    localparam act_e OWNER = (g < 2) ? ACT_XWIN : ACT_YWIN;
    localparam int LO = (g % 2) * 2;
    localparam logic [15:0] INIT = (g == 1) ? 16'(H_PIX - 1) :
                                   (g == 3) ? 16'(V_PIX - 1) : 16'd0;
    logic [15:0] r;
    logic        sel;
    assign sel = take && (act == OWNER);
    always_ff @(posedge clk) begin
      if (rst)
        r <= INIT;
      else if (sel && idx == IDX_W'(LO))
        r[7:0] <= dat_byte;
      else if (sel && idx == IDX_W'(LO + 1))
        r[15:8] <= dat_byte;
    end
    assign win_q[g] = r;
  end

endmodule

// File: rtl/wac_stepper.sv
`timescale 1ns/1ps
// X/Y counters: byte-wise load, and window-bounded stepping on each image byte.
module wac_stepper
  import wac_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  act_e             act,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       dat_byte,
  input  logic [1:0]       mode,
  input  logic [3:0][15:0] win,
  output logic             adv,
  output logic [15:0]      x_q,
  output logic [15:0]      y_q
);

  localparam logic [15:0] X_STEP = 16'd8;

  logic        x_at_end, y_at_end;
  logic [15:0] x_nxt, y_nxt;

  assign adv = take && (act == ACT_WNEW || act == ACT_WOLD);

  always_comb begin
    // compare byte columns, not pixels
    x_at_end = mode[0] ? ((x_q >> 3) >= (win[1] >> 3))
                       : ((x_q >> 3) <= (win[1] >> 3));
    y_at_end = mode[1] ? (y_q >= win[3]) : (y_q <= win[3]);
    if (x_at_end)
      x_nxt = win[0];
    else
      x_nxt = mode[0] ? x_q + X_STEP : x_q - X_STEP;
    if (!x_at_end)
      y_nxt = y_q;
    else if (y_at_end)
      y_nxt = win[2];
    else
      y_nxt = mode[1] ? y_q + 16'd1 : y_q - 16'd1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q <= '0;
      y_q <= '0;
    end else if (adv) begin
      x_q <= x_nxt;
      y_q <= y_nxt;
    end else if (take) begin
      if (act == ACT_XCNT && idx == IDX_W'(0)) x_q[7:0]  <= dat_byte;
      if (act == ACT_XCNT && idx == IDX_W'(1)) x_q[15:8] <= dat_byte;
      if (act == ACT_YCNT && idx == IDX_W'(0)) y_q[7:0]  <= dat_byte;
      if (act == ACT_YCNT && idx == IDX_W'(1)) y_q[15:8] <= dat_byte;
    end
  end

endmodule

// File: rtl/wac_addr_map.sv
`timescale 1ns/1ps
// Turns the counter position into a linear byte address and registers the write.
module wac_addr_map #(
  parameter int H_PIX  = 800,
  parameter int V_PIX  = 480,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              buf_old,
  input  logic [7:0]        dat_byte,
  input  logic [12:0]       col,
  input  logic [15:0]       row,
  output logic              mem_we,
  output logic              mem_buf,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_data
);

  localparam int BPR = H_PIX / 8;

  logic              in_frame;
  logic [ADDR_W-1:0] lin;

  assign in_frame = (col < 13'(BPR)) && (row < 16'(V_PIX));
  assign lin      = ADDR_W'(row * 16'(BPR)) + ADDR_W'(col);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we   <= 1'b0;
      mem_buf  <= 1'b0;
      mem_addr <= '0;
      mem_data <= '0;
    end else begin
      mem_we <= adv && in_frame;
      if (adv) begin
        mem_buf  <= buf_old;
        mem_addr <= lin;
        mem_data <= dat_byte;
      end
    end
  end

endmodule

// File: rtl/wac_addr_counter.sv
`timescale 1ns/1ps
module wac_addr_counter
  import wac_pkg::*;
#(
  parameter int H_PIX = 800,
  parameter int V_PIX = 480,
  localparam int FRAME_BYTES = (H_PIX / 8) * V_PIX,
  localparam int ADDR_W = $clog2(FRAME_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  input  logic              dat_valid,
  input  logic [7:0]        dat_byte,
  output logic              mem_we,
  output logic              mem_buf,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_data
);

  localparam int IDX_W = 3;

  act_e             act;
  logic [IDX_W-1:0] idx;
  logic             take;
  logic [1:0]       mode;
  logic [3:0][15:0] win;
  logic             adv;
  logic [15:0]      x_cnt, y_cnt;

  wac_cmd_track #(.IDX_W(IDX_W)) u_track (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .dat_valid(dat_valid), .act_q(act), .idx_q(idx), .take(take)
  );

  wac_win_regs #(.H_PIX(H_PIX), .V_PIX(V_PIX), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst), .take(take), .act(act), .idx(idx),
    .dat_byte(dat_byte), .mode_q(mode), .win_q(win)
  );

  wac_stepper #(.IDX_W(IDX_W)) u_step (
    .clk(clk), .rst(rst), .take(take), .act(act), .idx(idx),
    .dat_byte(dat_byte), .mode(mode), .win(win), .adv(adv),
    .x_q(x_cnt), .y_q(y_cnt)
  );

  wac_addr_map #(.H_PIX(H_PIX), .V_PIX(V_PIX), .ADDR_W(ADDR_W)) u_map (
    .clk(clk), .rst(rst), .adv(adv), .buf_old(act == ACT_WOLD),
    .dat_byte(dat_byte), .col(x_cnt[15:3]), .row(y_cnt),
    .mem_we(mem_we), .mem_buf(mem_buf), .mem_addr(mem_addr), .mem_data(mem_data)
  );

endmodule

// File: rtl/wac_addr_counter_chk.sv
`timescale 1ns/1ps
module wac_addr_counter_chk #(
  parameter int H_PIX = 800,
  parameter int V_PIX = 480,
  localparam int FRAME_BYTES = (H_PIX / 8) * V_PIX,
  localparam int ADDR_W = $clog2(FRAME_BYTES)
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              dat_valid,
  input logic [7:0]        dat_byte,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_data
);

  // R5
  write_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ($past(dat_valid) && !$past(cmd_valid)));

  // R5
  data_passthru_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_data == $past(dat_byte)));

  // R9
  cmd_drops_data_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !mem_we);

  // R10
  addr_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr < ADDR_W'(FRAME_BYTES)));

endmodule

bind wac_addr_counter wac_addr_counter_chk #(.H_PIX(H_PIX), .V_PIX(V_PIX)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .dat_valid(dat_valid),
  .dat_byte(dat_byte), .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data)
);

// File: tb/tb_wac_addr_counter.sv
`timescale 1ns/1ps
module tb_wac_addr_counter;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_code = 8'h00;
  logic        dat_valid = 1'b0;
  logic [7:0]  dat_byte = 8'h00;
  logic        mem_we, mem_buf;
  logic [15:0] mem_addr;
  logic [7:0]  mem_data;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  wac_addr_counter dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .dat_valid(dat_valid), .dat_byte(dat_byte), .mem_we(mem_we),
    .mem_buf(mem_buf), .mem_addr(mem_addr), .mem_data(mem_data)
  );

  // vector: [26] command, [25:18] byte, [17] check, [16] expect write, [15:0] address
  function automatic logic [26:0] vc(input logic [7:0] v);
    return {1'b1, v, 1'b0, 1'b0, 16'd0};
  endfunction
  function automatic logic [26:0] vd(input logic [7:0] v);
    return {1'b0, v, 1'b0, 1'b0, 16'd0};
  endfunction
  function automatic logic [26:0] vw(input logic [7:0] v, input logic [15:0] a);
    return {1'b0, v, 1'b1, 1'b1, a};
  endfunction

  localparam int NV = 48;
  localparam logic [26:0] VEC [NV] = '{
    // R4 R2 R3 R6 R7: X up, Y up, columns 1..2, rows 2..3
    vc(8'h11), vd(8'h03),
    vc(8'h44), vd(8'h08), vd(8'h00), vd(8'h17), vd(8'h00),
    vc(8'h45), vd(8'h02), vd(8'h00), vd(8'h03), vd(8'h00),
    vc(8'h4E), vd(8'h08), vd(8'h00),
    vc(8'h4F), vd(8'h02), vd(8'h00),
    vc(8'h24), vw(8'hA1, 16'd201), vw(8'hA2, 16'd202), vw(8'hA3, 16'd301),
    vw(8'hA4, 16'd302), vw(8'hA5, 16'd201),
    // R4 R6 R7: X down, Y up, start column 2 end column 1
    vc(8'h11), vd(8'h02),
    vc(8'h44), vd(8'h17), vd(8'h00), vd(8'h08), vd(8'h00),
    vc(8'h45), vd(8'h02), vd(8'h00), vd(8'h03), vd(8'h00),
    vc(8'h4E), vd(8'h17), vd(8'h00),
    vc(8'h4F), vd(8'h02), vd(8'h00),
    vc(8'h26), vw(8'hB1, 16'd202), vw(8'hB2, 16'd201), vw(8'hB3, 16'd302),
    vw(8'hB4, 16'd301), vw(8'hB5, 16'd202)
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic is_cmd, input logic [7:0] v);
    if (is_cmd) begin cmd_valid = 1'b1; cmd_code = v; end
    else begin dat_valid = 1'b1; dat_byte = v; end
    @(negedge clk);
    cmd_valid = 1'b0;
    dat_valid = 1'b0;
  endtask

  task automatic wr_chk(input string req, input logic [7:0] v, input logic [15:0] a);
    send(1'b0, v);
    chk(req, {31'd0, mem_we}, 32'd1);
    chk(req, {16'd0, mem_addr}, {16'd0, a});
    chk(req, {24'd0, mem_data}, {24'd0, v});
  endtask

  task automatic no_wr(input string req, input logic [7:0] v);
    send(1'b0, v);
    chk(req, {31'd0, mem_we}, 32'd0);
  endtask

  task automatic load4(input logic [7:0] op, input logic [15:0] s, input logic [15:0] e);
    send(1'b1, op);
    send(1'b0, s[7:0]); send(1'b0, s[15:8]);
    send(1'b0, e[7:0]); send(1'b0, e[15:8]);
  endtask

  task automatic load2(input logic [7:0] op, input logic [15:0] v);
    send(1'b1, op);
    send(1'b0, v[7:0]); send(1'b0, v[15:8]);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset strobe", {31'd0, mem_we}, 32'd0);

    // R8: data before any command is dropped
    no_wr("R8 idle data", 8'h5A);

    // R1: counters start at 0, X steps up
    send(1'b1, 8'h24);
    wr_chk("R1 first addr", 8'h11, 16'd0);
    wr_chk("R1 second addr", 8'h22, 16'd1);
    chk("R5 buffer new", {31'd0, mem_buf}, 32'd0);

    // R1 R6 R7: default window, last byte then full wrap
    load2(8'h4E, 16'd792);
    load2(8'h4F, 16'd479);
    send(1'b1, 8'h24);
    wr_chk("R6 last byte", 8'h33, 16'd47999);
    wr_chk("R7 frame wrap", 8'h44, 16'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][26], VEC[i][25:18]);
      if (VEC[i][17]) begin
        chk("R6 R7 table strobe", {31'd0, mem_we}, {31'd0, VEC[i][16]});
        chk("R5 table addr", {16'd0, mem_addr}, {16'd0, VEC[i][15:0]});
        chk("R5 table data", {24'd0, mem_data}, {24'd0, VEC[i][25:18]});
      end
    end
    chk("R5 buffer old", {31'd0, mem_buf}, 32'd1);

    // R8: surplus mode byte dropped, mode stays X up
    send(1'b1, 8'h11); send(1'b0, 8'h03); send(1'b0, 8'h00);
    load4(8'h44, 16'd0, 16'd799);
    load4(8'h45, 16'd0, 16'd479);
    load2(8'h4E, 16'd0);
    load2(8'h4F, 16'd5);
    send(1'b1, 8'h24);
    wr_chk("R8 surplus byte", 8'h61, 16'd500);
    wr_chk("R8 surplus byte", 8'h62, 16'd501);

    // R8: unknown command, data dropped, counters untouched
    send(1'b1, 8'h99);
    no_wr("R8 unknown cmd", 8'h63);
    send(1'b1, 8'h24);
    wr_chk("R8 counter kept", 8'h64, 16'd502);

    // R9: command and data together
    cmd_valid = 1'b1; cmd_code = 8'h24; dat_valid = 1'b1; dat_byte = 8'h65;
    @(negedge clk);
    cmd_valid = 1'b0; dat_valid = 1'b0;
    chk("R9 collide", {31'd0, mem_we}, 32'd0);
    wr_chk("R9 counter kept", 8'h66, 16'd503);

    // R10: row 480 outside frame, counter still moves
    load2(8'h4F, 16'd480);
    send(1'b1, 8'h24);
    no_wr("R10 out of frame", 8'h67);
    load2(8'h4F, 16'd0);
    send(1'b1, 8'h24);
    wr_chk("R10 counter moved", 8'h68, 16'd5);

    // R11: reversed rows, region y=10 h=3, columns 0..1
    send(1'b1, 8'h11); send(1'b0, 8'h01);
    load4(8'h44, 16'd0, 16'd15);
    load4(8'h45, 16'd469, 16'd467);
    load2(8'h4E, 16'd0);
    load2(8'h4F, 16'd469);
    send(1'b1, 8'h26);
    wr_chk("R11 top row", 8'h71, 16'd46900);
    chk("R11 buffer old", {31'd0, mem_buf}, 32'd1);
    wr_chk("R11 step", 8'h72, 16'd46901);
    wr_chk("R11 row down", 8'h73, 16'd46800);
    wr_chk("R11 step", 8'h74, 16'd46801);
    wr_chk("R11 last row", 8'h75, 16'd46700);
    wr_chk("R11 step", 8'h76, 16'd46701);
    wr_chk("R11 wrap", 8'h77, 16'd46900);

    finish_run();
  end

endmodule